// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a peripheral controller, reached over a byte-wide host I/O bus. Two adjacent I/O addresses form a register window: the lower one takes a register index, the upper one moves data to and from the indexed register. A strap input picks which of two base addresses the window occupies. The window stays shut until the host writes a four-byte unlock key to the index address. The last key byte depends on the strapped base.

Once the window is open, the host reaches a small set of global registers and a set of registers that a logical device number selects. The block drives a clock-select bit, a watchdog enable, an enable bit and a 16-bit I/O base for each serial device, and an active-low standby power-switch output. That output is computed combinationally from two sleep-state inputs and is gated by a register bit. The host closes the window again through a control register.

Top module: `cfg_port_ctrl`

## Requirements
- R1: With `strap_alt_base` low the index address is 0x002E and the data address 0x002F; with it high they are 0x004E and 0x004F. Host accesses to any other address have no effect, and reads there return 0xFF.
- R2: The window opens after four consecutive index-address writes: 0x87, 0x01, 0x55, and then 0x55 for base 0x002E or 0xAA for base 0x004E. It is open from the clock edge that captures the fourth write.
- R3: While the window is shut, any index-address write that does not match the expected key byte returns key matching to the first byte. That write does not count as a first byte, even if it is 0x87.
- R4: While the window is shut, data-address reads and index-address reads return 0xFF, and data-address writes change no register.
- R5: Register 0x02 is write-only and reads 0x00. Writing it with bit 1 set shuts the window, and the key must then be sent again.
- R6: Register 0x07 holds the 8-bit logical device number and reads back what was written. Registers 0x2A and 0x30 and above are banked by it.
- R7: Bit 0 of register 0x23 drives `clk_sel_24m` (1 selects 24 MHz, 0 selects 48 MHz) and reads back in bit 0.
- R8: With logical device 7 selected, register 0x72 controls `wdt_en`: a zero byte clears it and any non-zero byte sets it. With any other device selected, the same write leaves `wdt_en` unchanged.
- R9: Serial devices use logical device numbers 1 to NUM_SER. Each has its own enable at register 0x30 bit 0, its own base high byte at 0x60 and its own base low byte at 0x61, and all of these read back. Device k drives `dev_enable[k-1]` and `dev_iobase[16k-1:16k-16]`.
- R10: With logical device 7 selected, bit 7 of register 0x2A is the power-switch enable. While it is 0, `sb_switch_n` is 1. While it is 1, `sb_switch_n` = NAND(NOT `susb_n`, `susc_n`) in the same cycle as the inputs.
- R11: Reset shuts the window and clears the key matching, the index, the logical device number, the clock select, the power-switch enable and all serial-device registers. It sets `wdt_en` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt_base | input | 1 | Base select: 0 for 0x002E, 1 for 0x004E |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, combinational while `host_rd` is high |
| susb_n | input | 1 | Suspend-to-RAM sleep state, active low |
| susc_n | input | 1 | Soft-off sleep state, active low |
| clk_sel_24m | output | 1 | Input clock select (1 = 24 MHz) |
| wdt_en | output | 1 | Watchdog enable |
| dev_enable | output | NUM_SER | Serial device enables |
| dev_iobase | output | 16*NUM_SER | Serial device I/O bases |
| sb_switch_n | output | 1 | Standby power-switch output, active low |

## Verification
Every register output and every change of the key state is visible after the single clock edge that captures `host_wr`. The bench therefore drives each write for one cycle starting at a falling edge and checks the result on the next falling edge.

Read data and the power-switch output are combinational. The bench samples them one time unit after it changes the inputs, which is before any clock edge. A ignored write is checked by reading the register it would have reached, or by observing the output that register drives, after the window has been opened.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  // unlock key
  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_LAST_LO = 8'h55;
  localparam logic [7:0] KEY_LAST_HI = 8'hAA;

  // register indices
  localparam logic [7:0] IDX_CTRL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CLK     = 8'h23;
  localparam logic [7:0] IDX_PSW     = 8'h2A;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_WDT     = 8'h72;

  localparam logic [7:0] LDN_GPIO    = 8'h07;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_GOT1 = 2'd1,
    KEY_GOT2 = 2'd2,
    KEY_GOT3 = 2'd3
  } key_state_e;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_DEF = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              alt_base,
  output logic              idx_hit,
  output logic              dat_hit
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base    = alt_base ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_DEF);
    idx_hit = (addr == base);
    dat_hit = (addr == base + ADDR_W'(1));
  end
endmodule

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_base,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       unlocked
);
  key_state_e state_q, state_d;
  logic       unlocked_q, unlocked_d;
  logic [7:0] last_byte;

  assign last_byte = alt_base ? KEY_LAST_HI : KEY_LAST_LO;
  assign unlocked  = unlocked_q;

  always_comb begin
    state_d    = state_q;
    unlocked_d = unlocked_q;
    if (unlocked_q) begin
      if (exit_req) begin
        unlocked_d = 1'b0;
        state_d    = KEY_IDLE;
      end
    end else if (idx_wr) begin
      case (state_q)
        KEY_IDLE: state_d = (wdata == KEY_B0) ? KEY_GOT1 : KEY_IDLE;
        KEY_GOT1: state_d = (wdata == KEY_B1) ? KEY_GOT2 : KEY_IDLE;
        KEY_GOT2: state_d = (wdata == KEY_B2) ? KEY_GOT3 : KEY_IDLE;
        default: begin
          state_d = KEY_IDLE;
          if (wdata == last_byte) unlocked_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= KEY_IDLE;
      unlocked_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      unlocked_q <= unlocked_d;
    end
  end

  // R2
  unlock_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(idx_wr && state_q == KEY_GOT3));

  // R5
  relock_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked_q) |-> $past(exit_req));
endmodule

// File: rtl/cfg_standby_switch.sv
module cfg_standby_switch (
  input  logic enable,
  input  logic susb_n,
  input  logic susc_n,
  output logic sw_n
);
  always_comb begin
    if (enable) sw_n = ~((~susb_n) & susc_n);
    else        sw_n = 1'b1;
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_SER  = 2,
  parameter int SER_LDN0 = 1,
  localparam int BASE_W  = 16 * NUM_SER
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unlocked,
  input  logic               idx_wr,
  input  logic               dat_wr,
  input  logic [7:0]         wdata,
  output logic [7:0]         index,
  output logic [7:0]         dat_rdata,
  output logic               exit_req,
  output logic               clk_sel,
  output logic               wdt_en,
  output logic               psw_en,
  output logic [NUM_SER-1:0] dev_en,
  output logic [BASE_W-1:0]  dev_base
);
  logic       wr_en, idx_en;
  logic [7:0] index_q, index_d;
  logic [7:0] ldn_q, ldn_d;
  logic       clk_sel_q, clk_sel_d;
  logic       wdt_q, wdt_d;
  logic       psw_q, psw_d;
  logic       gpio_sel;

  logic [NUM_SER-1:0] act_q;
  logic [7:0]         hi_q [NUM_SER];
  logic [7:0]         lo_q [NUM_SER];

  assign wr_en    = dat_wr && unlocked;
  assign idx_en   = idx_wr && unlocked;
  assign gpio_sel = (ldn_q == LDN_GPIO);
  assign exit_req = wr_en && (index_q == IDX_CTRL) && wdata[1];

  // global and GPIO-device next state
  always_comb begin
    index_d   = index_q;
    ldn_d     = ldn_q;
    clk_sel_d = clk_sel_q;
    wdt_d     = wdt_q;
    psw_d     = psw_q;
    if (idx_en) index_d = wdata;
    if (wr_en) begin
      case (index_q)
        IDX_LDN: ldn_d     = wdata;
        IDX_CLK: clk_sel_d = wdata[0];
        IDX_PSW: if (gpio_sel) psw_d = wdata[7];
        IDX_WDT: if (gpio_sel) wdt_d = |wdata;
        default: ;
      endcase
    end
    if (exit_req) index_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q   <= 8'h00;
      ldn_q     <= 8'h00;
      clk_sel_q <= 1'b0;
      wdt_q     <= 1'b1;
      psw_q     <= 1'b0;
    end else begin
      index_q   <= index_d;
      ldn_q     <= ldn_d;
      clk_sel_q <= clk_sel_d;
      wdt_q     <= wdt_d;
      psw_q     <= psw_d;
    end
  end

  // per-device serial registers
  for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
    logic       sel, act_d;
    logic [7:0] hi_d, lo_d;

    assign sel = (ldn_q == 8'(SER_LDN0 + g));

    always_comb begin
      act_d = act_q[g];
      hi_d  = hi_q[g];
      lo_d  = lo_q[g];
      if (wr_en && sel) begin
        case (index_q)
          IDX_ACT:     act_d = wdata[0];
          IDX_BASE_HI: hi_d  = wdata;
          IDX_BASE_LO: lo_d  = wdata;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[g] <= 1'b0;
        hi_q[g]  <= 8'h00;
        lo_q[g]  <= 8'h00;
      end else begin
        act_q[g] <= act_d;
        hi_q[g]  <= hi_d;
        lo_q[g]  <= lo_d;
      end
    end

    assign dev_base[16*g +: 16] = {hi_q[g], lo_q[g]};
  end

  // read mux
  always_comb begin
    dat_rdata = 8'h00;
    case (index_q)
      IDX_LDN: dat_rdata = ldn_q;
      IDX_CLK: dat_rdata = {7'b0, clk_sel_q};
      IDX_PSW: dat_rdata = gpio_sel ? {psw_q, 7'b0} : 8'h00;
      IDX_WDT: dat_rdata = gpio_sel ? {7'b0, wdt_q} : 8'h00;
      default: ;
    endcase
    for (int g = 0; g < NUM_SER; g++) begin
      if (ldn_q == 8'(SER_LDN0 + g)) begin
        case (index_q)
          IDX_ACT:     dat_rdata = {7'b0, act_q[g]};
          IDX_BASE_HI: dat_rdata = hi_q[g];
          IDX_BASE_LO: dat_rdata = lo_q[g];
          default: ;
        endcase
      end
    end
  end

  assign index   = index_q;
  assign clk_sel = clk_sel_q;
  assign wdt_en  = wdt_q;
  assign psw_en  = psw_q;
  assign dev_en  = act_q;

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && dat_wr) |=> ($stable(ldn_q) && $stable(clk_sel_q) && $stable(act_q)));

  // R7
  clk_sel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel_q) |-> $past(dat_wr && unlocked));

  // R8
  wdt_gpio_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wdt_q) |-> $past(gpio_sel && dat_wr && unlocked));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter int          ADDR_W   = 16,
  parameter int          NUM_SER  = 2,
  parameter logic [15:0] BASE_DEF = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E,
  localparam int         BASE_W   = 16 * NUM_SER
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_alt_base,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [7:0]         host_wdata,
  input  logic               host_wr,
  input  logic               host_rd,
  output logic [7:0]         host_rdata,
  input  logic               susb_n,
  input  logic               susc_n,
  output logic               clk_sel_24m,
  output logic               wdt_en,
  output logic [NUM_SER-1:0] dev_enable,
  output logic [BASE_W-1:0]  dev_iobase,
  output logic               sb_switch_n
);
  logic       idx_hit, dat_hit, unlocked, exit_req, psw_en;
  logic [7:0] index, dat_rdata;

  cfg_addr_decode #(.ADDR_W(ADDR_W), .BASE_DEF(BASE_DEF), .BASE_ALT(BASE_ALT)) u_dec (
    .addr(host_addr), .alt_base(strap_alt_base), .idx_hit(idx_hit), .dat_hit(dat_hit)
  );

  cfg_key_unlock u_key (
    .clk(clk), .rst_n(rst_n), .alt_base(strap_alt_base),
    .idx_wr(host_wr && idx_hit), .wdata(host_wdata),
    .exit_req(exit_req), .unlocked(unlocked)
  );

  cfg_reg_bank #(.NUM_SER(NUM_SER), .SER_LDN0(1)) u_bank (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked),
    .idx_wr(host_wr && idx_hit), .dat_wr(host_wr && dat_hit), .wdata(host_wdata),
    .index(index), .dat_rdata(dat_rdata), .exit_req(exit_req),
    .clk_sel(clk_sel_24m), .wdt_en(wdt_en), .psw_en(psw_en),
    .dev_en(dev_enable), .dev_base(dev_iobase)
  );

  cfg_standby_switch u_sw (
    .enable(psw_en), .susb_n(susb_n), .susc_n(susc_n), .sw_n(sb_switch_n)
  );

  always_comb begin
    host_rdata = 8'hFF;
    if (host_rd && unlocked) begin
      if (dat_hit)      host_rdata = dat_rdata;
      else if (idx_hit) host_rdata = index;
    end
  end

  // R10
  switch_active_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_switch_n |-> (psw_en && !susb_n && susc_n));

  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !unlocked) |-> (host_rdata == 8'hFF));
endmodule

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_alt_base;
  logic [15:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_wr, host_rd;
  logic [7:0]  host_rdata;
  logic        susb_n, susc_n;
  logic        clk_sel_24m, wdt_en, sb_switch_n;
  logic [1:0]  dev_enable;
  logic [31:0] dev_iobase;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] ib, db;

  always #4 clk = ~clk;

  cfg_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_alt_base(strap_alt_base),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
    .host_rd(host_rd), .host_rdata(host_rdata), .susb_n(susb_n), .susc_n(susc_n),
    .clk_sel_24m(clk_sel_24m), .wdt_en(wdt_en), .dev_enable(dev_enable),
    .dev_iobase(dev_iobase), .sb_switch_n(sb_switch_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 16'h0000;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    host_rd = 1'b0; host_addr = 16'h0000;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_wr(ib, idx);
    io_wr(db, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    io_wr(ib, idx);
    io_rd(db, d);
  endtask

  task automatic send_key(input logic [7:0] last);
    io_wr(ib, 8'h87); io_wr(ib, 8'h01); io_wr(ib, 8'h55); io_wr(ib, last);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    do_reset();
    check("R11 clk_sel", clk_sel_24m, 0);
    check("R11 wdt_en", wdt_en, 1);
    check("R11 dev_enable", dev_enable, 0);
    check("R11 dev_iobase", dev_iobase, 0);
    check("R11 sb_switch_n", sb_switch_n, 1);
    io_rd(ib, d);
    check("R11 locked index read", d, 8'hFF);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    io_wr(ib, 8'h07);
    io_wr(db, 8'h33);
    io_wr(ib, 8'h23);
    io_wr(db, 8'h01);
    io_rd(db, d);
    check("R4 locked data read", d, 8'hFF);
    check("R4 locked write clk_sel", clk_sel_24m, 0);
  endtask

  task automatic t_wrong_byte;
    logic [7:0] d;
    io_wr(ib, 8'h87); io_wr(ib, 8'h01); io_wr(ib, 8'h00);
    io_wr(ib, 8'h55); io_wr(ib, 8'h55);
    io_rd(db, d);
    check("R3 broken key stays locked", d, 8'hFF);
    io_wr(ib, 8'h87); io_wr(ib, 8'h01); io_wr(ib, 8'h87);
    io_wr(ib, 8'h01); io_wr(ib, 8'h55); io_wr(ib, 8'h55);
    io_rd(db, d);
    check("R3 wrong byte 0x87 not a first byte", d, 8'hFF);
    send_key(8'hAA);
    io_rd(db, d);
    check("R2 wrong last byte for base 0x2E", d, 8'hFF);
  endtask

  task automatic t_unlock;
    logic [7:0] d;
    send_key(8'h55);
    reg_rd(8'h07, d);
    check("R2 open, R4 ldn untouched while locked", d, 8'h00);
    io_rd(ib, d);
    check("R2 index readback", d, 8'h07);
    io_rd(16'h0030, d);
    check("R1 other address reads FF", d, 8'hFF);
  endtask

  task automatic t_ldn_clk;
    logic [7:0] d;
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h07, d);
    check("R6 ldn readback", d, 8'h05);
    reg_wr(8'h23, 8'h01);
    check("R7 clk_sel set", clk_sel_24m, 1);
    reg_rd(8'h23, d);
    check("R7 clk_sel readback", d, 8'h01);
  endtask

  task automatic t_wdt;
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h72, 8'h00);
    check("R8 wdt untouched in device 1", wdt_en, 1);
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h72, 8'h00);
    check("R8 wdt cleared", wdt_en, 0);
    reg_wr(8'h72, 8'h10);
    check("R8 wdt set by non-zero", wdt_en, 1);
  endtask

  task automatic t_switch;
    logic [7:0] d;
    susb_n = 1'b0; susc_n = 1'b1; #1;
    check("R10 disabled inactive", sb_switch_n, 1);
    reg_wr(8'h2A, 8'h80);
    susb_n = 1'b1; susc_n = 1'b1; #1;
    check("R10 S0 inactive", sb_switch_n, 1);
    susb_n = 1'b0; susc_n = 1'b1; #1;
    check("R10 S3 active", sb_switch_n, 0);
    susb_n = 1'b0; susc_n = 1'b0; #1;
    check("R10 S5 inactive", sb_switch_n, 1);
    reg_rd(8'h2A, d);
    check("R10 enable readback", d, 8'h80);
    susb_n = 1'b0; susc_n = 1'b1;
    reg_wr(8'h2A, 8'h00);
    check("R10 disabled again", sb_switch_n, 1);
    susb_n = 1'b1;
  endtask

  task automatic t_serial;
    logic [7:0] d;
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8); reg_wr(8'h30, 8'h01);
    reg_wr(8'h07, 8'h02);
    reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'hE8);
    check("R9 bases per device", dev_iobase, 32'h02E8_03F8);
    check("R9 enables per device", dev_enable, 2'b01);
    reg_wr(8'h07, 8'h01);
    reg_rd(8'h61, d);
    check("R9 low byte readback", d, 8'hF8);
    reg_rd(8'h30, d);
    check("R9 enable readback", d, 8'h01);
  endtask

  task automatic t_exit;
    logic [7:0] d;
    reg_rd(8'h02, d);
    check("R5 control reads zero", d, 8'h00);
    reg_wr(8'h02, 8'h02);
    io_rd(db, d);
    check("R5 shut after exit", d, 8'hFF);
  endtask

  task automatic t_alt_base;
    logic [7:0] d;
    strap_alt_base = 1'b1;
    ib = 16'h004E; db = 16'h004F;
    io_wr(16'h002E, 8'h87); io_wr(16'h002E, 8'h01);
    io_wr(16'h002E, 8'h55); io_wr(16'h002E, 8'hAA);
    io_rd(db, d);
    check("R1 old base ignored", d, 8'hFF);
    send_key(8'h55);
    io_rd(db, d);
    check("R2 base 0x4E needs 0xAA", d, 8'hFF);
    send_key(8'hAA);
    reg_rd(8'h07, d);
    check("R1 alternate base open", d, 8'h01);
  endtask

  task automatic t_reset_again;
    logic [7:0] d;
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h2A, 8'h80);
    reg_wr(8'h72, 8'h00);
    do_reset();
    check("R11 clk_sel cleared", clk_sel_24m, 0);
    check("R11 wdt set", wdt_en, 1);
    check("R11 serial cleared", dev_iobase, 0);
    susb_n = 1'b0; susc_n = 1'b1; #1;
    check("R11 switch enable cleared", sb_switch_n, 1);
    io_rd(db, d);
    check("R11 locked again", d, 8'hFF);
    send_key(8'hAA);
    reg_rd(8'h07, d);
    check("R11 ldn cleared", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; strap_alt_base = 1'b0;
    host_addr = 16'h0; host_wdata = 8'h0; host_wr = 1'b0; host_rd = 1'b0;
    susb_n = 1'b1; susc_n = 1'b1;
    ib = 16'h002E; db = 16'h002F;
    fork
      begin
        t_reset_state();
        t_locked();
        t_wrong_byte();
        t_unlock();
        t_ldn_clk();
        t_wdt();
        t_switch();
        t_serial();
        t_exit();
        t_alt_base();
        t_reset_again();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule